// File: doc/BRIEF.md
# Synthesizer PLL power and lock sequencer

This block is the control side of the reference PLL that clocks a four-channel frequency synthesizer. Software reaches it through a small register port. One address takes commands and another takes the 3-bit multiplier code. The block drives the PLL's control pins: an active-low soft reset, a reference-bandwidth code, the multiplier field and a power-down control whose polarity is a parameter. It also presents the effective feedback multiplier, which is the code plus 16, to a behavioural VCO model.

An enable command starts a fixed bring-up in which each step takes one clock. First the soft reset is released. Next the bandwidth code is set to the good-reference value 0. Then the stored multiplier is loaded onto the PLL field. Last, the power-down control is driven to its power-up level. The block then waits for the lock input, and it raises a sticky timeout flag if lock does not appear within a parameterised number of clock cycles. A disable command reverses the bring-up: power goes down first and soft reset is asserted on the next clock.

When a build has no lock input, the block reports lock as soon as power is up. The bandwidth codes 1, 2 and 3 mean very bad, bad and very good reference. Code 3 is the value the block holds out of reset.

Top module: `fsyn_pll_ctrl`

## Requirements
- R1: Out of reset the power-down control sits at its power-down level (equal to PD_POL), the soft reset is asserted (0), the bandwidth code is 3, the multiplier field and the stored code are 0, and enabled, locked and timeout are all 0.
- R2: A write of bit 0 to address 0 while idle starts the bring-up, one step per clock after the write edge, in this order: the soft reset goes to 1, then the bandwidth code goes to 0, then the multiplier field takes the stored code, then the power-down control goes to its power-up level.
- R3: The effective multiplier output always equals the multiplier field plus 16.
- R4: A write to address 1 carries the code in data bits 2:0. It is accepted only if the reference frequency (REF_KHZ) times (code+16) lies within 384000 to 660000 kHz, and an illegal code leaves both the stored code and the field unchanged. With a 30000 kHz reference, codes 0 to 6 are legal and code 7 is rejected.
- R5: Reading address 1 returns the stored code in bits 2:0. A legal code write updates the stored code at once. The PLL field follows the write in the next cycle only while the PLL is powered; while the PLL is off, the field changes only at the load step of R2.
- R6: When the lock input is high during the wait, locked rises one clock later, and locked is only ever high while the PLL is powered.
- R7: If lock is not seen during the first LOCK_TIMEOUT wait cycles, timeout is set and locked stays 0 even if lock arrives later. Timeout stays set through a disable and is cleared only by the next accepted enable command.
- R8: A write of bit 1 to address 0 while waiting, locked or timed out powers the PLL down on the first clock and asserts soft reset on the second clock, and enabled drops together with the power.
- R9: Enabled is 1 exactly when the power-down control differs from PD_POL: with PD_POL=1 the PLL is powered by a 0, and with PD_POL=0 it is powered by a 1.
- R10: An enable command is ignored while the PLL is waiting or locked, and when one write sets both command bits the disable wins. Reading address 0 returns enabled, locked and timeout in bits 0, 1 and 2.
- R11: With the lock input absent (HAS_LOCK=0), locked rises in the same cycle that power comes up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 command, 1 multiplier code |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address: 0 status, 1 stored code |
| rd_data | output | DATA_W | Read data, combinational |
| lock_i | input | 1 | Lock status from the PLL |
| pll_nreset_o | output | 1 | PLL soft reset, active low |
| pll_bw_o | output | 2 | Reference-bandwidth code |
| pll_mult_o | output | MULT_W | Multiplier field driven to the PLL |
| pll_pd_o | output | 1 | Power-down control, polarity PD_POL |
| vco_mult_o | output | VCO_W | Effective feedback multiplier (field + 16) |
| enabled_o | output | 1 | PLL powered |
| locked_o | output | 1 | Lock reached after bring-up |
| timeout_o | output | 1 | Lock wait timed out (sticky) |

## Verification
The bring-up is watched clock by clock after an enable command. This separates a correct step order from one in which two steps are swapped or merged. Three lock patterns are applied: lock arriving partway through the wait, lock never arriving, and lock arriving only after the timeout. Together they tell a real lock from an expired wait, and show that the timeout is sticky.

Multiplier writes are made with the PLL off and then with it running. The codes used are the boundary-legal code 6 and the illegal code 7, so deferred loading can be told apart from direct update, and range rejection from acceptance. A second instance with the inverted polarity and no lock input runs alongside the first, which separates the polarity handling from the lock handling.

// File: rtl/fsyn_pll_pkg.sv
package fsyn_pll_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_RELEASE,
      ST_BAND,
      ST_LOAD,
      ST_POWER,
      ST_WAIT,
      ST_ON,
      ST_FAULT,
      ST_PDOWN,
      ST_HOLD
   } seq_state_t;

   typedef enum logic [1:0] {
      BW_GOOD      = 2'd0,
      BW_VERY_BAD  = 2'd1,
      BW_BAD       = 2'd2,
      BW_VERY_GOOD = 2'd3
   } bw_code_t;

   localparam longint unsigned VCO_MIN_KHZ = 384000;
   localparam longint unsigned VCO_MAX_KHZ = 660000;
   localparam int unsigned     REF_MAX_KHZ = 40000;

endpackage

// File: rtl/fsyn_pll_cfg.sv
module fsyn_pll_cfg
   import fsyn_pll_pkg::*;
#(
   parameter int unsigned MULT_W      = 3,
   parameter int unsigned MULT_OFFSET = 16,
   parameter int unsigned REF_KHZ     = 30000,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              powered,
   input  logic              load_now,
   output logic [MULT_W-1:0] shadow_o,
   output logic [MULT_W-1:0] field_o,
   output logic              cmd_en_o,
   output logic              cmd_dis_o
);
   localparam int unsigned      NCODES = 1 << MULT_W;
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_MULT = ADDR_W'(1);

   logic [NCODES-1:0] legal;
   logic [MULT_W-1:0] wr_code;
   logic              mult_hit;
   wire               unused_hi = ^wr_data[DATA_W-1:MULT_W];

   genvar g;
   generate
      for (g = 0; g < NCODES; g++) begin : g_legal
         localparam longint unsigned VCO_KHZ =
            longint'(REF_KHZ) * longint'(g + MULT_OFFSET);
         assign legal[g] = (VCO_KHZ >= VCO_MIN_KHZ) && (VCO_KHZ <= VCO_MAX_KHZ);
      end
   endgenerate

   assign wr_code   = wr_data[MULT_W-1:0];
   assign mult_hit  = wr_en && (wr_addr == A_MULT) && legal[wr_code];
   assign cmd_en_o  = wr_en && (wr_addr == A_CMD) && wr_data[0];
   assign cmd_dis_o = wr_en && (wr_addr == A_CMD) && wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_o <= '0;
         field_o  <= '0;
      end else begin
         if (mult_hit)
            shadow_o <= wr_code;
         if (load_now)
            field_o <= shadow_o;
         else if (mult_hit && powered)
            field_o <= wr_code;
      end
   end

endmodule

// File: rtl/fsyn_pll_lock_timer.sv
module fsyn_pll_lock_timer #(
   parameter int unsigned TIMEOUT = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_wait,
   output logic expired_o
);
   localparam int unsigned CNT_W = $clog2(TIMEOUT);

   logic [CNT_W-1:0] cnt;

   assign expired_o = in_wait && (cnt == CNT_W'(TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!in_wait)
         cnt <= '0;
      else if (!expired_o)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/fsyn_pll_seq.sv
module fsyn_pll_seq
   import fsyn_pll_pkg::*;
#(
   parameter bit HAS_RESET = 1'b1,
   parameter bit HAS_BW    = 1'b1,
   parameter bit HAS_LOCK  = 1'b1,
   parameter bit PD_POL    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_en,
   input  logic       cmd_dis,
   input  logic       lock_i,
   input  logic       expired,
   output logic       nreset_o,
   output logic [1:0] bw_o,
   output logic       pd_o,
   output logic       load_o,
   output logic       in_wait_o,
   output logic       locked_o,
   output logic       timeout_o
);
   seq_state_t state;
   logic       pd_q;
   logic       timeout_q;

   assign pd_o      = pd_q;
   assign timeout_o = timeout_q;
   assign load_o    = (state == ST_LOAD);
   assign in_wait_o = (state == ST_WAIT);
   assign locked_o  = (state == ST_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OFF;
         pd_q      <= PD_POL;
         timeout_q <= 1'b0;
      end else begin
         case (state)
            ST_OFF: begin
               if (cmd_en && !cmd_dis) begin
                  state     <= ST_RELEASE;
                  timeout_q <= 1'b0;
               end
            end
            ST_FAULT: begin
               if (cmd_dis)
                  state <= ST_PDOWN;
               else if (cmd_en) begin
                  state     <= ST_RELEASE;
                  timeout_q <= 1'b0;
               end
            end
            ST_RELEASE: state <= ST_BAND;
            ST_BAND:    state <= ST_LOAD;
            ST_LOAD:    state <= ST_POWER;
            ST_POWER: begin
               pd_q  <= ~PD_POL;
               state <= HAS_LOCK ? ST_WAIT : ST_ON;
            end
            ST_WAIT: begin
               if (cmd_dis)
                  state <= ST_PDOWN;
               else if (lock_i)
                  state <= ST_ON;
               else if (expired) begin
                  state     <= ST_FAULT;
                  timeout_q <= 1'b1;
               end
            end
            ST_ON: begin
               if (cmd_dis)
                  state <= ST_PDOWN;
            end
            ST_PDOWN: begin
               pd_q  <= PD_POL;
               state <= ST_HOLD;
            end
            ST_HOLD:  state <= ST_OFF;
            default:  state <= ST_OFF;
         endcase
      end
   end

   generate
      if (HAS_RESET) begin : g_rst
         logic nrst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               nrst_q <= 1'b0;
            else if (state == ST_RELEASE)
               nrst_q <= 1'b1;
            else if (state == ST_HOLD)
               nrst_q <= 1'b0;
         end
         assign nreset_o = nrst_q;
      end else begin : g_no_rst
         assign nreset_o = 1'b1;
      end

      if (HAS_BW) begin : g_bw
         logic [1:0] bw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bw_q <= BW_VERY_GOOD;
            else if (state == ST_BAND)
               bw_q <= BW_GOOD;
         end
         assign bw_o = bw_q;
      end else begin : g_no_bw
         assign bw_o = BW_GOOD;
      end
   endgenerate

endmodule

// File: rtl/fsyn_pll_ctrl.sv
module fsyn_pll_ctrl
   import fsyn_pll_pkg::*;
#(
   parameter int unsigned MULT_W       = 3,
   parameter int unsigned MULT_OFFSET  = 16,
   parameter int unsigned REF_KHZ      = 30000,
   parameter int unsigned LOCK_TIMEOUT = 1250000,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned DATA_W       = 8,
   parameter bit          HAS_RESET    = 1'b1,
   parameter bit          HAS_BW       = 1'b1,
   parameter bit          HAS_LOCK     = 1'b1,
   parameter bit          PD_POL       = 1'b1,
   localparam int unsigned VCO_W       = $clog2(MULT_OFFSET + (1 << MULT_W))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              lock_i,
   output logic              pll_nreset_o,
   output logic [1:0]        pll_bw_o,
   output logic [MULT_W-1:0] pll_mult_o,
   output logic              pll_pd_o,
   output logic [VCO_W-1:0]  vco_mult_o,
   output logic              enabled_o,
   output logic              locked_o,
   output logic              timeout_o
);
   generate
      if (REF_KHZ > REF_MAX_KHZ) begin : g_bad_ref
         $error("reference above the supported maximum");
      end
      if (DATA_W < MULT_W + 1 || DATA_W < 3) begin : g_bad_data
         $error("data width too small for fields");
      end
      if (LOCK_TIMEOUT < 2) begin : g_bad_timeout
         $error("lock timeout must be at least 2 cycles");
      end
   endgenerate

   logic [MULT_W-1:0] shadow;
   logic              cmd_en, cmd_dis, load_now, in_wait, expired;

   fsyn_pll_cfg #(
      .MULT_W(MULT_W), .MULT_OFFSET(MULT_OFFSET), .REF_KHZ(REF_KHZ),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .powered(enabled_o), .load_now(load_now),
      .shadow_o(shadow), .field_o(pll_mult_o),
      .cmd_en_o(cmd_en), .cmd_dis_o(cmd_dis)
   );

   fsyn_pll_seq #(
      .HAS_RESET(HAS_RESET), .HAS_BW(HAS_BW), .HAS_LOCK(HAS_LOCK), .PD_POL(PD_POL)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
      .lock_i(lock_i), .expired(expired), .nreset_o(pll_nreset_o),
      .bw_o(pll_bw_o), .pd_o(pll_pd_o), .load_o(load_now),
      .in_wait_o(in_wait), .locked_o(locked_o), .timeout_o(timeout_o)
   );

   fsyn_pll_lock_timer #(
      .TIMEOUT(LOCK_TIMEOUT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .in_wait(in_wait), .expired_o(expired)
   );

   assign enabled_o  = (pll_pd_o != PD_POL);
   assign vco_mult_o = VCO_W'(pll_mult_o) + VCO_W'(MULT_OFFSET);

   always_comb begin
      case (rd_addr)
         ADDR_W'(0): rd_data = {{(DATA_W-3){1'b0}}, timeout_o, locked_o, enabled_o};
         ADDR_W'(1): rd_data = {{(DATA_W-MULT_W){1'b0}}, shadow};
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/fsyn_pll_ctrl_chk.sv
module fsyn_pll_ctrl_chk
   import fsyn_pll_pkg::*;
#(
   parameter int unsigned MULT_W      = 3,
   parameter int unsigned MULT_OFFSET = 16,
   parameter int unsigned REF_KHZ     = 30000,
   parameter bit          HAS_RESET   = 1'b1,
   parameter bit          HAS_LOCK    = 1'b1,
   parameter bit          PD_POL      = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_i,
   input logic              pll_nreset_o,
   input logic [1:0]        pll_bw_o,
   input logic [MULT_W-1:0] pll_mult_o,
   input logic              pll_pd_o,
   input logic              enabled_o,
   input logic              locked_o,
   input logic              timeout_o
);
   longint unsigned vco_khz;
   assign vco_khz = longint'(REF_KHZ) * (longint'(pll_mult_o) + longint'(MULT_OFFSET));

   p_setup_before_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enabled_o) |-> (pll_nreset_o && pll_bw_o == BW_GOOD));

   p_field_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enabled_o |-> (vco_khz >= VCO_MIN_KHZ && vco_khz <= VCO_MAX_KHZ));

   p_lock_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> enabled_o);

   p_lock_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LOCK && $rose(locked_o)) |-> $past(lock_i));

   p_timeout_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !locked_o);

   p_reset_after_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_RESET && $fell(enabled_o)) |=> !pll_nreset_o);

   p_locked_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> (pll_pd_o == !PD_POL));

endmodule

bind fsyn_pll_ctrl fsyn_pll_ctrl_chk #(
   .MULT_W(MULT_W), .MULT_OFFSET(MULT_OFFSET), .REF_KHZ(REF_KHZ),
   .HAS_RESET(HAS_RESET), .HAS_LOCK(HAS_LOCK), .PD_POL(PD_POL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .pll_nreset_o(pll_nreset_o),
   .pll_bw_o(pll_bw_o), .pll_mult_o(pll_mult_o), .pll_pd_o(pll_pd_o),
   .enabled_o(enabled_o), .locked_o(locked_o), .timeout_o(timeout_o)
);

// File: tb/fsyn_pll_ctrl_tb.sv
module fsyn_pll_ctrl_tb;
   localparam int T = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic       lock = 1'b0;

   logic [7:0] rd_data, nl_rd;
   logic       nreset, pd, enabled, locked, timeout;
   logic [1:0] bw;
   logic [2:0] mult;
   logic [4:0] vco;
   logic       nl_nreset, nl_pd, nl_enabled, nl_locked, nl_timeout;
   logic [1:0] nl_bw;
   logic [2:0] nl_mult;
   logic [4:0] nl_vco;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fsyn_pll_ctrl #(.LOCK_TIMEOUT(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .lock_i(lock), .pll_nreset_o(nreset),
      .pll_bw_o(bw), .pll_mult_o(mult), .pll_pd_o(pd), .vco_mult_o(vco),
      .enabled_o(enabled), .locked_o(locked), .timeout_o(timeout));

   fsyn_pll_ctrl #(.LOCK_TIMEOUT(T), .HAS_LOCK(1'b0), .PD_POL(1'b0)) u_dut_nl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(nl_rd), .lock_i(1'b0), .pll_nreset_o(nl_nreset),
      .pll_bw_o(nl_bw), .pll_mult_o(nl_mult), .pll_pd_o(nl_pd), .vco_mult_o(nl_vco),
      .enabled_o(nl_enabled), .locked_o(nl_locked), .timeout_o(nl_timeout));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1", "pd", pd, 1);
      chk("R1", "nreset", nreset, 0);
      chk("R1", "bw", bw, 3);
      chk("R1", "mult", mult, 0);
      chk("R1", "enabled", enabled, 0);
      chk("R1", "locked", locked, 0);
      chk("R1", "timeout", timeout, 0);
      chk("R3", "vco at reset", vco, 16);
      chk("R9", "pol0 pd at reset", nl_pd, 0);
      chk("R9", "pol0 enabled at reset", nl_enabled, 0);
      rd(2'd1, v);
      chk("R1", "stored code", v, 0);
   endtask

   task automatic t_mult_off();
      logic [7:0] v;
      wr(2'd1, 8'd5);
      rd(2'd1, v);
      chk("R5", "stored code after write", v, 5);
      chk("R5", "field held while off", mult, 0);
      wr(2'd1, 8'd7);
      rd(2'd1, v);
      chk("R4", "illegal code 7 rejected", v, 5);
      wr(2'd1, 8'd6);
      rd(2'd1, v);
      chk("R4", "boundary code 6 accepted", v, 6);
      wr(2'd1, 8'd5);
      rd(2'd1, v);
      chk("R4", "code 5 accepted", v, 5);
   endtask

   task automatic t_enable_lock();
      logic [7:0] v;
      wr(2'd0, 8'h01);
      chk("R2", "reset still held after command edge", nreset, 0);
      @(negedge clk);
      chk("R2", "step1 reset released", nreset, 1);
      chk("R2", "step1 bw unchanged", bw, 3);
      @(negedge clk);
      chk("R2", "step2 bw good", bw, 0);
      chk("R2", "step2 field not yet loaded", mult, 0);
      @(negedge clk);
      chk("R2", "step3 field loaded", mult, 5);
      chk("R3", "vco 5+16", vco, 21);
      chk("R2", "step3 still powered down", pd, 1);
      @(negedge clk);
      chk("R2", "step4 powered up", pd, 0);
      chk("R9", "enabled with pd 0", enabled, 1);
      chk("R6", "not locked before lock", locked, 0);
      chk("R11", "no-lock variant locked at power-up", nl_locked, 1);
      chk("R9", "pol0 powered by 1", nl_pd, 1);
      chk("R9", "pol0 enabled", nl_enabled, 1);
      repeat (5) @(negedge clk);
      chk("R6", "still waiting", locked, 0);
      lock = 1'b1;
      @(negedge clk);
      chk("R6", "locked after lock", locked, 1);
      chk("R7", "no timeout", timeout, 0);
      rd(2'd0, v);
      chk("R10", "status word", v, 3);
   endtask

   task automatic t_mult_live();
      wr(2'd1, 8'd2);
      chk("R5", "field follows while powered", mult, 2);
      chk("R3", "vco 2+16", vco, 18);
      wr(2'd1, 8'd7);
      chk("R4", "illegal code ignored while on", mult, 2);
   endtask

   task automatic t_ignore_en();
      wr(2'd0, 8'h01);
      repeat (3) @(negedge clk);
      chk("R10", "enable ignored when locked", locked, 1);
      chk("R10", "reset unchanged", nreset, 1);
      chk("R10", "power unchanged", pd, 0);
   endtask

   task automatic t_disable();
      wr(2'd0, 8'h03);
      chk("R8", "power still up at command edge", pd, 0);
      @(negedge clk);
      chk("R10", "disable won over enable", pd, 1);
      chk("R8", "enabled dropped", enabled, 0);
      chk("R8", "reset not yet asserted", nreset, 1);
      @(negedge clk);
      chk("R8", "reset asserted second", nreset, 0);
      chk("R8", "locked cleared", locked, 0);
      chk("R9", "pol0 powered down to 0", nl_pd, 0);
      lock = 1'b0;
   endtask

   task automatic t_timeout();
      wr(2'd0, 8'h01);
      repeat (4) @(negedge clk);
      chk("R2", "powered for timeout run", pd, 0);
      repeat (T - 1) @(negedge clk);
      chk("R7", "no timeout one cycle early", timeout, 0);
      @(negedge clk);
      chk("R7", "timeout set", timeout, 1);
      chk("R7", "not locked", locked, 0);
      lock = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7", "late lock ignored", locked, 0);
      wr(2'd0, 8'h02);
      repeat (2) @(negedge clk);
      chk("R8", "off after disable", enabled, 0);
      chk("R7", "timeout sticky through disable", timeout, 1);
      wr(2'd0, 8'h01);
      chk("R7", "timeout cleared by enable", timeout, 0);
      repeat (5) @(negedge clk);
      chk("R6", "relocked", locked, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mult_off();
      t_enable_lock();
      t_mult_live();
      t_ignore_en();
      t_disable();
      t_timeout();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule